// File: doc/BRIEF.md
# Configurable Format Serial Transmitter

This block turns bytes from host logic into an asynchronous serial line. The host checks the buffer-empty flag, presents a byte together with a one-cycle load strobe, and the block frames it as one low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. The line rests high between frames. A 3-bit format code selects one of eight frame shapes. A 2-bit divide code decides whether each bit lasts one, sixteen or sixty-four periods of an external baud clock. The fourth divide value holds the transmitter in reset.

The transmitter has two stages. A holding register takes the next byte while the shift register is still sending the current one. When the current frame ends and a byte is waiting, the next frame begins at once, with no idle time in between. The baud clock is treated as asynchronous: it is synchronised and edge-detected into single-cycle ticks, and a prescaler counts those ticks to produce bit boundaries. Format and divide codes are sampled only at the moment a frame begins, so software can change them freely while a frame is on the line.

Top module: `cfx_uart_tx`

## Requirements
- R1: While `rst_i` is high, and in the clock cycle after it falls, `txd_o` is 1 and `empty_o` is 1. The reset is synchronous and active high.
- R2: Each frame on `txd_o` is one start bit at 0, then the data bits least significant first, then the parity bit when the format has one, then the stop bits at 1. When no frame is being sent, `txd_o` is 1.
- R3: `fmt_i` selects the frame shape: 000 is 7 data bits, even parity, 2 stop; 001 is 7 data, odd, 2 stop; 010 is 7 data, even, 1 stop; 011 is 7 data, odd, 1 stop; 100 is 8 data, no parity, 2 stop; 101 is 8 data, no parity, 1 stop; 110 is 8 data, even, 1 stop; 111 is 8 data, odd, 1 stop.
- R4: In 7-bit formats only `data_i[6:0]` are sent and bit 7 has no effect. Parity covers only the data bits that are sent. With even parity, the sent data bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number.
- R5: With `div_i` at 00, 01 or 10, every bit of a frame lasts exactly 1, 16 or 64 rising edges of `bclk_i`.
- R6: A cycle with `load_i` high (and `div_i` not 11) captures `data_i` into the holding register, and `empty_o` is 0 in the following cycle.
- R7: `empty_o` returns to 1 in the same cycle in which the held byte moves into the shift register and its start bit appears on `txd_o`. If a byte is already held when a frame's last stop bit ends, the next start bit follows with no idle bit.
- R8: `fmt_i` and `div_i` are sampled when a frame starts. Changing them during a frame does not affect that frame.
- R9: While `div_i` is 11, the transmitter is held in reset. In the next cycle `txd_o` is 1 and `empty_o` is 1, any frame in progress is abandoned, a held byte is discarded, and loads are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | One-cycle strobe that captures `data_i` |
| data_i | input | 8 | Byte to transmit |
| fmt_i | input | 3 | Frame format code |
| div_i | input | 2 | Baud divide code (00 x1, 01 x16, 10 x64, 11 hold in reset) |
| bclk_i | input | 1 | External baud clock, asynchronous to `clk_i` |
| txd_o | output | 1 | Serial data line, idles high |
| empty_o | output | 1 | Holding register can take a byte |

## Verification
The assertions check, on every cycle, the register-level relations: the reset and hold-in-reset states, `empty_o` falling after a load, the start bit appearing whenever `empty_o` rises, the line staying high while no frame is in progress, and the latched divide setting changing only at bit boundaries. The waveform-level properties need the bench's scenarios: frame shape for all eight formats, parity values, bit length under each divide, gap-free back-to-back frames, and a setting change during a frame leaving that frame intact. The bench decodes `txd_o` at bit midpoints and compares each frame with one built from the format table.

// File: rtl/cfx_tx_pkg.sv
package cfx_tx_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FMT_W   = 3;
  localparam int unsigned DIV_W   = 2;
  localparam int unsigned FRAME_W = 12;
  localparam int unsigned LEFT_W  = $clog2(FRAME_W);
  localparam logic [DIV_W-1:0] DIV_HOLD = 2'b11;

  typedef struct packed {
    logic eight;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_cfg_t;

  // Format code to frame shape; the receiver on the far side uses the same table.
  function automatic frame_cfg_t decode_fmt(input logic [FMT_W-1:0] code);
    frame_cfg_t f;
    f.eight = code[2];
    if (!code[2]) begin
      f.par_en   = 1'b1;
      f.par_odd  = code[0];
      f.two_stop = ~code[1];
    end else begin
      f.par_en   = code[1];
      f.par_odd  = code[1] & code[0];
      f.two_stop = (code[1:0] == 2'b00);
    end
    return f;
  endfunction

  // Start + data + parity + stops
  function automatic logic [LEFT_W-1:0] frame_bits(input frame_cfg_t f);
    return LEFT_W'(9) + LEFT_W'(f.eight) + LEFT_W'(f.par_en) + LEFT_W'(f.two_stop);
  endfunction
endpackage

// File: rtl/cfx_baud_tick.sv
module cfx_baud_tick #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_MID     = 16,
  parameter int unsigned DIV_HI      = 64
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       bclk_i,
  input  logic [1:0] div_sel_i,
  output logic       tick_o
);
  localparam int unsigned CNT_W = $clog2(DIV_HI);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   edge_w;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       limit_w;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], bclk_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign edge_w = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_comb begin
    case (div_sel_i)
      2'b00:   limit_w = '0;
      2'b01:   limit_w = CNT_W'(DIV_MID - 1);
      default: limit_w = CNT_W'(DIV_HI - 1);
    endcase
  end

  // Free-running prescaler; ">=" lets a smaller divide take over cleanly.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (edge_w) begin
      cnt_q <= (cnt_q >= limit_w) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = edge_w & (cnt_q >= limit_w);
endmodule

// File: rtl/cfx_tx_engine.sv
module cfx_tx_engine
  import cfx_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tick_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              busy_o,
  output logic [DIV_W-1:0]  div_lat_o
);
  logic [BYTE_W-1:0]  hold_q;
  logic               empty_q;
  logic               busy_q;
  logic               txd_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [LEFT_W-1:0]  left_q;
  logic [DIV_W-1:0]   div_lat_q;

  frame_cfg_t         cfg_w;
  logic [FRAME_W-1:0] frame_w;
  logic [LEFT_W-1:0]  nbits_w;
  logic               par_w;
  logic               start_w;

  // Frame image built from the held byte and the current settings.
  always_comb begin
    cfg_w   = decode_fmt(fmt_i);
    nbits_w = frame_bits(cfg_w);
    par_w   = cfg_w.par_odd;
    frame_w = '1;
    frame_w[0] = 1'b0;
    for (int i = 0; i < BYTE_W; i++) begin
      if (i < BYTE_W - 1 || cfg_w.eight) begin
        frame_w[1+i] = hold_q[i];
        par_w        = par_w ^ hold_q[i];
      end
    end
    if (cfg_w.par_en) begin
      if (cfg_w.eight) frame_w[BYTE_W+1] = par_w;
      else             frame_w[BYTE_W]   = par_w;
    end
  end

  // A frame starts on a bit boundary: from idle, or as the last stop bit ends.
  assign start_w = tick_i && !empty_q && (!busy_q || left_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hold_q    <= '0;
      empty_q   <= 1'b1;
      busy_q    <= 1'b0;
      txd_q     <= 1'b1;
      shreg_q   <= '1;
      left_q    <= '0;
      div_lat_q <= '0;
    end else begin
      if (load_i) begin
        hold_q  <= data_i;
        empty_q <= 1'b0;
      end else if (start_w) begin
        empty_q <= 1'b1;
      end

      if (start_w) begin
        busy_q    <= 1'b1;
        txd_q     <= frame_w[0];
        shreg_q   <= {1'b1, frame_w[FRAME_W-1:1]};
        left_q    <= nbits_w - 1'b1;
        div_lat_q <= div_i;
      end else if (busy_q && tick_i) begin
        if (left_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          txd_q   <= shreg_q[0];
          shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
          left_q  <= left_q - 1'b1;
        end
      end
    end
  end

  assign txd_o     = txd_q;
  assign empty_o   = empty_q;
  assign busy_o    = busy_q;
  assign div_lat_o = div_lat_q;
endmodule

// File: rtl/cfx_uart_tx.sv
module cfx_uart_tx
  import cfx_tx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_MID     = 16,
  parameter int unsigned DIV_HI      = 64
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic [2:0] fmt_i,
  input  logic [1:0] div_i,
  input  logic       bclk_i,
  output logic       txd_o,
  output logic       empty_o
);
  logic             hold_rst_w;
  logic             tick_w;
  logic             busy_w;
  logic [DIV_W-1:0] div_lat_w;
  logic [DIV_W-1:0] div_sel_w;

  assign hold_rst_w = rst_i | (div_i == DIV_HOLD);
  // Within a frame the prescaler follows the divide latched at its start.
  assign div_sel_w  = busy_w ? div_lat_w : div_i;

  cfx_baud_tick #(
    .SYNC_STAGES (SYNC_STAGES),
    .DIV_MID     (DIV_MID),
    .DIV_HI      (DIV_HI)
  ) i_tick (
    .clk_i     (clk_i),
    .rst_i     (hold_rst_w),
    .bclk_i    (bclk_i),
    .div_sel_i (div_sel_w),
    .tick_o    (tick_w)
  );

  cfx_tx_engine i_engine (
    .clk_i     (clk_i),
    .rst_i     (hold_rst_w),
    .load_i    (load_i),
    .data_i    (data_i),
    .fmt_i     (fmt_i),
    .div_i     (div_i),
    .tick_i    (tick_w),
    .txd_o     (txd_o),
    .empty_o   (empty_o),
    .busy_o    (busy_w),
    .div_lat_o (div_lat_w)
  );
endmodule

// File: rtl/cfx_uart_tx_chk.sv
module cfx_uart_tx_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       load_i,
  input logic [1:0] div_i,
  input logic       txd_o,
  input logic       empty_o,
  input logic       busy,
  input logic       tick,
  input logic [1:0] div_lat
);
  // R1
  p_reset_state_r1: assert property (@(posedge clk_i)
    rst_i |=> (txd_o && empty_o));

  // R6
  p_load_fills_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && div_i != 2'b11) |=> !empty_o);

  // R9
  p_hold_reset_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (div_i == 2'b11) |=> (txd_o && empty_o));

  // R7: the byte leaving the holding register shows up as a start bit
  p_start_on_move_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(empty_o) && $past(div_i) != 2'b11) |-> !txd_o);

  // R2: idle line is high
  p_idle_high_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy |-> txd_o);

  // R8: latched divide changes only at a bit boundary
  p_div_frozen_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy && $past(busy) && !$past(tick)) |-> $stable(div_lat));
endmodule

bind cfx_uart_tx cfx_uart_tx_chk i_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .load_i  (load_i),
  .div_i   (div_i),
  .txd_o   (txd_o),
  .empty_o (empty_o),
  .busy    (busy_w),
  .tick    (tick_w),
  .div_lat (div_lat_w)
);

// File: tb/test_cfx_uart_tx.sv
`timescale 1ns/1ps
module test_cfx_uart_tx;
  localparam int TXC_P = 4;  // baud clock period in system clocks

  typedef struct {
    logic [7:0] data;
    logic [2:0] fmt;
    logic [1:0] div;
    bit         b2b;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [7:0] data = '0;
  logic [2:0] fmt = '0;
  logic [1:0] div = '0;
  logic       bclk = 1'b0;
  logic       txd;
  logic       empty;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  bit    mon_en = 0;
  bit    aligned = 0;
  item_t exp_q[$];

  cfx_uart_tx i_cfx_uart_tx (
    .clk_i(clk), .rst_i(rst), .load_i(load), .data_i(data), .fmt_i(fmt),
    .div_i(div), .bclk_i(bclk), .txd_o(txd), .empty_o(empty)
  );

  always #2 clk = ~clk;

  initial begin
    forever begin
      repeat (TXC_P/2) @(negedge clk);
      bclk = ~bclk;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int mult(input logic [1:0] d);
    case (d)
      2'b00:   return 1;
      2'b01:   return 16;
      default: return 64;
    endcase
  endfunction

  // Frame image from the format table of R3 and the parity rule of R4
  function automatic void exp_frame(input logic [7:0] d, input logic [2:0] f,
                                    output logic [11:0] bits, output int n);
    int nd; bit pe; bit po; int ns; bit p;
    case (f)
      3'd0: begin nd = 7; pe = 1; po = 0; ns = 2; end
      3'd1: begin nd = 7; pe = 1; po = 1; ns = 2; end
      3'd2: begin nd = 7; pe = 1; po = 0; ns = 1; end
      3'd3: begin nd = 7; pe = 1; po = 1; ns = 1; end
      3'd4: begin nd = 8; pe = 0; po = 0; ns = 2; end
      3'd5: begin nd = 8; pe = 0; po = 0; ns = 1; end
      3'd6: begin nd = 8; pe = 1; po = 0; ns = 1; end
      default: begin nd = 8; pe = 1; po = 1; ns = 1; end
    endcase
    bits = '1;
    bits[0] = 1'b0;
    p = po;
    for (int i = 0; i < nd; i++) begin
      bits[1+i] = d[i];
      p = p ^ d[i];
    end
    if (pe) bits[1+nd] = p;
    n = 1 + nd + int'(pe) + ns;
  endfunction

  // Line decoder: samples every bit at its midpoint
  initial begin
    item_t it;
    int T; int half; int n;
    logic [11:0] eb; logic [11:0] rcv;
    forever begin
      if (!aligned) begin
        @(negedge clk);
        while (!(mon_en && txd == 1'b0 && exp_q.size() > 0)) @(negedge clk);
      end
      aligned = 0;
      it = exp_q.pop_front();
      T = mult(it.div) * TXC_P;
      half = T / 2;
      exp_frame(it.data, it.fmt, eb, n);
      rcv = '1;
      repeat (half) @(negedge clk);
      rcv[0] = txd;
      for (int b = 1; b < n; b++) begin
        repeat (T) @(negedge clk);
        rcv[b] = txd;
      end
      // R2 R3 R4 R5 R8: whole frame as built from the settings at load time
      check(rcv == eb, "R2/R3/R4/R5/R8 frame", {20'd0, rcv}, {20'd0, eb});
      if (exp_q.size() > 0 && exp_q[0].b2b) begin
        repeat (T - half) @(negedge clk);
        check(txd == 1'b0, "R7 back-to-back start", {31'd0, txd}, 32'd0);
        aligned = 1;
      end
    end
  end

  task automatic send(input logic [7:0] d, input logic [2:0] f, input logic [1:0] v, input bit b2b);
    item_t it;
    while (!empty) @(negedge clk);
    fmt = f; div = v; data = d; load = 1'b1;
    it.data = d; it.fmt = f; it.div = v; it.b2b = b2b;
    exp_q.push_back(it);
    @(negedge clk);
    load = 1'b0;
    check(empty == 1'b0, "R6 empty falls after load", {31'd0, empty}, 32'd0);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (70 * 11 * TXC_P) begin
      @(negedge clk);
      if (empty && txd) break;
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_7c41));
    repeat (5) @(negedge clk);
    // R1: outputs during and after reset
    check(txd == 1'b1 && empty == 1'b1, "R1 in reset", {30'd0, txd, empty}, 32'd3);
    rst = 1'b0;
    @(negedge clk);
    check(txd == 1'b1 && empty == 1'b1, "R1 after reset", {30'd0, txd, empty}, 32'd3);
    mon_en = 1;

    // R3: every format once at x1; R4: bit 7 ignored in 7-bit formats
    for (int f = 0; f < 8; f++) send(8'hB6 ^ 8'(f), 3'(f), 2'b00, 1'b0);
    drain();
    send(8'h80, 3'd0, 2'b00, 1'b0);
    drain();
    send(8'hFF, 3'd3, 2'b00, 1'b0);
    drain();
    send(8'h7F, 3'd6, 2'b00, 1'b0);
    drain();

    // R5: x16 and x64 timing
    send(8'h3C, 3'd5, 2'b01, 1'b0);
    drain();
    send(8'hC3, 3'd7, 2'b10, 1'b0);
    drain();

    // R7 and R8: second byte waits in holding, settings changed mid-frame
    send(8'h5A, 3'd4, 2'b01, 1'b0);
    send(8'hA5, 3'd1, 2'b00, 1'b1);
    @(negedge clk);
    check(empty == 1'b0, "R7 holding stays full mid-frame", {31'd0, empty}, 32'd0);
    drain();

    // Random streams
    for (int s = 0; s < 5; s++) begin
      for (int k = 0; k < 6; k++) begin
        logic [1:0] v;
        int r;
        r = int'($urandom % 8);
        v = (r < 4) ? 2'b00 : (r < 7) ? 2'b01 : 2'b10;
        send(8'($urandom), 3'($urandom), v, k != 0);
      end
      drain();
    end

    // R9: hold-in-reset code abandons a frame and ignores loads
    mon_en = 0;
    fmt = 3'd5; div = 2'b01; data = 8'h00; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    while (txd) @(negedge clk);
    repeat (20) @(negedge clk);
    div = 2'b11;
    @(negedge clk);
    check(txd == 1'b1 && empty == 1'b1, "R9 hold abandons frame", {30'd0, txd, empty}, 32'd3);
    data = 8'h00; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
    check(empty == 1'b1, "R9 load ignored in hold", {31'd0, empty}, 32'd1);
    div = 2'b00;
    begin
      bit stayed;
      stayed = 1;
      repeat (16 * TXC_P) begin
        @(negedge clk);
        if (!txd || !empty) stayed = 0;
      end
      check(stayed, "R9 no frame after release", {31'd0, stayed}, 32'd1);
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule